// File: doc/BRIEF.md
# Loopback Latency Capture Unit

This block sits between a register bus, the digital-to-analog converter feed and the analog-to-digital converter output of a radio loopback setup. It generates a quarter-rate complex test tone, sends it as one interleaved word stream (I word, then Q word) toward the transmit converter, and holds that stream at zero until a software-written trigger bit is set. The transmitted pair and the received pair of every sample period are stored together as one 64-bit entry in an on-chip capture buffer. A fixed delay line in front of the buffer means the buffer also holds a short stretch of samples from before the moment it was armed.

A sample period (a "pair") lasts two clocks. In the first clock the output word carries I and `dac_q_phase` is low. In the second clock it carries Q and `dac_q_phase` is high. The received I/Q pair is sampled on the clock edge that ends each pair.

Alongside the buffer, a counter measures the round trip directly. It counts pairs from the first tone pair to the first received pair whose I magnitude exceeds a programmable threshold. Software reads the result and the buffer without any post-processing.

Top module: `echo_latency_capture`

## Requirements
- R1: `dac_q_phase` alternates on every clock after reset, and is low in the first clock after reset is released. In each pair, `dac_word` carries I while the flag is low and Q while it is high.
- R2: `dac_word` is zero while the trigger bit is low. A write of 1 to bit 0 at address 0, accepted on the edge that ends pair t, makes pair t+2 the first tone pair.
- R3: From the first tone pair onward, the k-th pair carries I = A, 0, -A, 0 and Q = 0, A, 0, -A for k mod 4 = 0, 1, 2, 3, where A is the amplitude parameter.
- R4: Clearing the trigger bit, accepted on the edge ending pair t, gives zero words from pair t+2 on. The next trigger restarts the tone at k = 0.
- R5: A capture entry is 64 bits wide. Transmit I is in bits 63:48, transmit Q in 47:32, receive I in 31:16 and receive Q in 15:0.
- R6: Writing 1 to bit 1 at address 0 arms the capture. Bit 1 acts as a one-shot and is not stored. If that write is accepted on the edge ending pair a, entry 0 holds pair a+1-MARK_DLY and each later entry holds the next pair.
- R7: Capture stops after L entries, where L is the value at address 1, and a value of 0 or a value above DEPTH means DEPTH. Entries at index L and above are left untouched. `cap_done` rises after the last write, stays high, and is cleared by the next arm.
- R8: `echo_lat` counts the pairs from the first tone pair to the first received pair whose |receive I| is strictly greater than the threshold at address 2. An echo D pairs late reads D. The value then stays frozen and `echo_seen` is high until the next trigger rise.
- R9: Without an echo, `echo_lat` stops at 2^LAT_W-1 and `echo_seen` stays low.
- R10: `rd_data` shows the entry at `rd_addr` one clock after the address is applied.
- R11: After reset the trigger is low, the capture is not armed, and `cap_done`, `echo_seen`, `echo_lat` and `dac_word` are all zero.
- R12: The magnitude test uses the absolute value, so a negative received I beyond the threshold ends the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 capture length, 2 echo threshold |
| cfg_wdata | input | 16 | Register write data |
| dac_word | output | 16 | Interleaved signed I/Q word toward the transmit converter |
| dac_q_phase | output | 1 | High while `dac_word` carries Q |
| adc_i | input | 16 | Received signed I, sampled at the end of each pair |
| adc_q | input | 16 | Received signed Q, sampled at the end of each pair |
| rd_addr | input | clog2(DEPTH) | Capture buffer read address |
| rd_data | output | 64 | Capture entry, one clock of read latency |
| cap_done | output | 1 | Capture finished |
| echo_lat | output | LAT_W | Trigger-to-echo distance in pairs |
| echo_seen | output | 1 | An echo above the threshold has been found |

## Verification
An error in the tone phase or in the gate shows up on `dac_word` within two clocks, because each pair is checked against the arithmetic tone sequence. A wrong depth in the delay line or a wrong write pointer shifts every captured entry against the pairs the bench recorded at the ports. The shift is visible as soon as the buffer is read back. A counter that starts late, stops on the wrong magnitude test or wraps instead of saturating leaves a wrong value on `echo_lat` once the echo pair has passed.

// File: rtl/elc_pkg.sv
package elc_pkg;

    typedef logic signed [15:0] sample_t;

    // one stored sample period; field order fixes the 64-bit read word
    typedef struct packed {
        sample_t tx_i;
        sample_t tx_q;
        sample_t rx_i;
        sample_t rx_q;
    } cap_entry_t;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_LEN  = 2'd1,
        REG_THR  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    localparam int CTRL_TRIG_BIT = 0;
    localparam int CTRL_ARM_BIT  = 1;

    // quarter-rate complex exponential: phase 0..3
    function automatic sample_t tone_word(input logic [1:0] idx,
                                          input logic is_q,
                                          input sample_t amp);
        sample_t r;
        case (idx)
            2'd0:    r = is_q ? sample_t'(0) : amp;
            2'd1:    r = is_q ? amp : sample_t'(0);
            2'd2:    r = is_q ? sample_t'(0) : sample_t'(-amp);
            default: r = is_q ? sample_t'(-amp) : sample_t'(0);
        endcase
        return r;
    endfunction

    // absolute value widened so that -32768 is represented
    function automatic logic [16:0] mag17(input sample_t v);
        logic signed [16:0] e;
        e = {v[15], v};
        return (e < 0) ? 17'(-e) : 17'(e);
    endfunction

endpackage

// File: rtl/elc_tone.sv
module elc_tone
    import elc_pkg::*;
#(
    parameter sample_t AMP = 16'sd8192
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    trig,
    output sample_t word,
    output logic    q_phase,
    output logic    tone_on
);

    logic       sub_q;   // 0: I slot, 1: Q slot
    logic       en_q;    // gate decided at each pair boundary
    logic [1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q <= 1'b0;
            en_q  <= 1'b0;
            idx_q <= '0;
        end else begin
            sub_q <= ~sub_q;
            if (sub_q) begin
                en_q  <= trig;
                idx_q <= (en_q && trig) ? idx_q + 2'd1 : 2'd0;
            end
        end
    end

    assign word    = en_q ? tone_word(idx_q, sub_q, AMP) : '0;
    assign q_phase = sub_q;
    assign tone_on = en_q;

    // R2: a non-zero I word needs the trigger seen at the previous boundary
    assert_gate_from_trigger_R2: assert property (@(posedge clk) disable iff (rst)
        (!sub_q && word != '0) |-> $past(trig));

    // R1: the slot flag alternates every clock
    assert_slot_alternates_R1: assert property (@(posedge clk) disable iff (rst)
        sub_q |=> !sub_q);

endmodule

// File: rtl/elc_pair_delay.sv
module elc_pair_delay
    import elc_pkg::*;
#(
    parameter int MARK_DLY = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pair_end,
    input  sample_t    word,
    input  sample_t    rx_i,
    input  sample_t    rx_q,
    output cap_entry_t ent,
    output logic       ent_v
);

    localparam int EW = $bits(cap_entry_t);
    localparam int CW = EW * MARK_DLY;

    sample_t    hold_i;
    cap_entry_t pair_q;
    logic       pv;
    logic       dv;
    logic [CW-1:0] chain;

    // split the interleaved stream back into one I/Q pair per period
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_i <= '0;
            pair_q <= '0;
            pv     <= 1'b0;
        end else begin
            pv <= pair_end;
            if (!pair_end) begin
                hold_i <= word;
            end else begin
                pair_q <= '{tx_i: hold_i, tx_q: word, rx_i: rx_i, rx_q: rx_q};
            end
        end
    end

    // start-marking delay, one stage per pair
    generate
        if (MARK_DLY == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst)     chain <= '0;
                else if (pv) chain <= pair_q;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst)     chain <= '0;
                else if (pv) chain <= {chain[CW-EW-1:0], pair_q};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) dv <= 1'b0;
        else     dv <= pv;
    end

    assign ent   = chain[CW-1 -: EW];
    assign ent_v = dv;

    // R6: one entry per two-clock pair, never back to back
    assert_entry_spacing_R6: assert property (@(posedge clk) disable iff (rst)
        ent_v |=> !ent_v);

endmodule

// File: rtl/elc_capture.sv
module elc_capture
    import elc_pkg::*;
#(
    parameter int DEPTH = 4096,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int LEN_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic [LEN_W-1:0]  len,
    input  cap_entry_t        ent,
    input  logic              ent_v,
    input  logic [ADDR_W-1:0] rd_addr,
    output cap_entry_t        rd_data,
    output logic              done
);

    localparam logic [LEN_W-1:0] FULL = LEN_W'(DEPTH);

    cap_entry_t        mem [DEPTH];
    logic              active;
    logic [ADDR_W-1:0] wptr;
    logic [LEN_W-1:0]  len_lat;
    logic [LEN_W-1:0]  len_eff;
    logic              we;
    logic              last;

    assign len_eff = (len == '0 || len > FULL) ? FULL : len;
    assign we      = active && ent_v && !arm;
    assign last    = ({1'b0, wptr} == len_lat - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            wptr    <= '0;
            len_lat <= FULL;
            done    <= 1'b0;
        end else if (arm) begin
            active  <= 1'b1;
            wptr    <= '0;
            len_lat <= len_eff;
            done    <= 1'b0;
        end else if (we) begin
            if (last) begin
                active <= 1'b0;
                done   <= 1'b1;
            end else begin
                wptr <= wptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (we) mem[wptr] <= ent;
        rd_data <= mem[rd_addr];
    end

    // R7: the write pointer stays inside the programmed length
    assert_wptr_in_len_R7: assert property (@(posedge clk) disable iff (rst)
        active |-> ({1'b0, wptr} < len_lat));

    // R7: done holds until a new arm
    assert_done_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !arm) |=> done);

    // R7: a finished capture never writes
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !we);

endmodule

// File: rtl/elc_latency.sv
module elc_latency
    import elc_pkg::*;
#(
    parameter int LAT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pair_end,
    input  logic             tone_on,
    input  sample_t          rx_i,
    input  logic [15:0]      thr,
    output logic [LAT_W-1:0] cnt,
    output logic             hit
);

    localparam logic [LAT_W-1:0] CNT_MAX = '1;

    logic en_was;
    logic running;
    logic start;
    logic over;

    assign start = pair_end && tone_on && !en_was;
    assign over  = mag17(rx_i) > {1'b0, thr};

    always_ff @(posedge clk) begin
        if (rst) begin
            en_was  <= 1'b0;
            running <= 1'b0;
            cnt     <= '0;
            hit     <= 1'b0;
        end else if (pair_end) begin
            en_was <= tone_on;
            if (start) begin
                hit     <= over;
                running <= !over;
                cnt     <= over ? '0 : LAT_W'(1);
            end else if (running) begin
                if (over) begin
                    hit     <= 1'b1;
                    running <= 1'b0;
                end else if (cnt != CNT_MAX) begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R8: once the echo is found the result is frozen
    assert_result_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (hit && !start) |=> (hit && $stable(cnt)));

    // R9: a saturated count never wraps
    assert_count_saturates_R9: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && !start) |=> (cnt == CNT_MAX));

    // R8: a found echo stops the count
    assert_hit_stops_R8: assert property (@(posedge clk) disable iff (rst)
        hit |-> !running);

endmodule

// File: rtl/echo_latency_capture.sv
module echo_latency_capture
    import elc_pkg::*;
#(
    parameter int AMP      = 8192,
    parameter int DEPTH    = 4096,
    parameter int MARK_DLY = 8,
    parameter int LAT_W    = 16,
    localparam int ADDR_W  = $clog2(DEPTH),
    localparam int LEN_W   = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       dac_word,
    output logic              dac_q_phase,
    input  logic [15:0]       adc_i,
    input  logic [15:0]       adc_q,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [63:0]       rd_data,
    output logic              cap_done,
    output logic [LAT_W-1:0]  echo_lat,
    output logic              echo_seen
);

    localparam sample_t AMP_S = sample_t'(AMP);

    logic             trig_q;
    logic             arm_p;
    logic [LEN_W-1:0] len_q;
    logic [15:0]      thr_q;

    sample_t    word;
    logic       q_phase;
    logic       tone_on;
    cap_entry_t ent;
    logic       ent_v;
    cap_entry_t rd_ent;

    // control registers
    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= 1'b0;
            arm_p  <= 1'b0;
            len_q  <= '0;
            thr_q  <= '0;
        end else begin
            arm_p <= 1'b0;
            if (cfg_we) begin
                case (reg_sel_e'(cfg_addr))
                    REG_CTRL: begin
                        trig_q <= cfg_wdata[CTRL_TRIG_BIT];
                        arm_p  <= cfg_wdata[CTRL_ARM_BIT];
                    end
                    REG_LEN:  len_q <= cfg_wdata[LEN_W-1:0];
                    REG_THR:  thr_q <= cfg_wdata;
                    default:  ;
                endcase
            end
        end
    end

    elc_tone #(.AMP(AMP_S)) u_tone (
        .clk     (clk),
        .rst     (rst),
        .trig    (trig_q),
        .word    (word),
        .q_phase (q_phase),
        .tone_on (tone_on)
    );

    elc_pair_delay #(.MARK_DLY(MARK_DLY)) u_pair (
        .clk      (clk),
        .rst      (rst),
        .pair_end (q_phase),
        .word     (word),
        .rx_i     (sample_t'(adc_i)),
        .rx_q     (sample_t'(adc_q)),
        .ent      (ent),
        .ent_v    (ent_v)
    );

    elc_capture #(.DEPTH(DEPTH)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .arm     (arm_p),
        .len     (len_q),
        .ent     (ent),
        .ent_v   (ent_v),
        .rd_addr (rd_addr),
        .rd_data (rd_ent),
        .done    (cap_done)
    );

    elc_latency #(.LAT_W(LAT_W)) u_lat (
        .clk      (clk),
        .rst      (rst),
        .pair_end (q_phase),
        .tone_on  (tone_on),
        .rx_i     (sample_t'(adc_i)),
        .thr      (thr_q),
        .cnt      (echo_lat),
        .hit      (echo_seen)
    );

    assign dac_word    = word;
    assign dac_q_phase = q_phase;
    assign rd_data     = rd_ent;

endmodule

// File: tb/tb_echo_latency_capture.sv
`timescale 1ns/1ps
module tb_echo_latency_capture;

    localparam int DEPTH = 64;
    localparam int DLY   = 3;
    localparam int LATW  = 6;
    localparam int AMP   = 1000;
    localparam int AW    = 6;
    localparam int NP    = 4096;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst;
    logic          cfg_we;
    logic [1:0]    cfg_addr;
    logic [15:0]   cfg_wdata;
    logic [15:0]   dac_word;
    logic          dac_q_phase;
    logic [15:0]   adc_i;
    logic [15:0]   adc_q;
    logic [AW-1:0] rd_addr;
    logic [63:0]   rd_data;
    logic          cap_done;
    logic [LATW-1:0] echo_lat;
    logic          echo_seen;

    echo_latency_capture #(.AMP(AMP), .DEPTH(DEPTH), .MARK_DLY(DLY), .LAT_W(LATW)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .dac_word(dac_word), .dac_q_phase(dac_q_phase), .adc_i(adc_i), .adc_q(adc_q),
        .rd_addr(rd_addr), .rd_data(rd_data), .cap_done(cap_done),
        .echo_lat(echo_lat), .echo_seen(echo_seen)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic signed [15:0] bI [NP];
    logic signed [15:0] bQ [NP];
    logic signed [15:0] rI [NP];
    logic signed [15:0] rQ [NP];
    logic [63:0] old_cap [DEPTH];

    int p = 0;
    logic signed [15:0] cur_i;
    bit last_ph = 1'b1;
    int echo_d = 5;
    int echo_s = 1;
    int ph_err = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic signed [15:0] tone(input int k, input bit q);
        case (k % 4)
            0:       return q ? 16'sd0 : 16'(AMP);
            1:       return q ? 16'(AMP) : 16'sd0;
            2:       return q ? 16'sd0 : 16'(-AMP);
            default: return q ? 16'(-AMP) : 16'sd0;
        endcase
    endfunction

    // observe one clock of the port stream and drive the echo
    task automatic sample();
        if (dac_q_phase == last_ph) ph_err++;
        if (!dac_q_phase) begin
            cur_i = dac_word;
            if (p >= echo_d) begin
                adc_i = 16'(echo_s * int'(bI[p-echo_d]));
                adc_q = 16'(echo_s * int'(bQ[p-echo_d]));
            end else begin
                adc_i = '0;
                adc_q = '0;
            end
            last_ph = 1'b0;
        end else begin
            bI[p] = cur_i;
            bQ[p] = dac_word;
            rI[p] = adc_i;
            rQ[p] = adc_q;
            p++;
            last_ph = 1'b1;
        end
    endtask

    task automatic step();
        @(negedge clk);
        sample();
    endtask

    task automatic wait_ph1();
        do step(); while (!last_ph);
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [63:0] v);
        rd_addr = AW'(a);
        step();
        v = rd_data;
    endtask

    initial begin
        #600000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int a, t, p0, q0, n, qq, toff;
        logic [63:0] v, ex;
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        adc_i = '0; adc_q = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        chk(dac_word == 0 && cap_done == 0, "R11 reset outputs", {dac_word, 15'd0, cap_done}, 0);
        chk(echo_lat == 0 && echo_seen == 0, "R11 reset latency", {echo_lat, echo_seen}, 0);
        rst = 1'b0;
        #1;
        sample();
        chk(dac_q_phase == 0 && dac_word == 0, "R11 first cycle after reset", {dac_q_phase, dac_word}, 0);

        // ---- run 1: full-depth capture, echo 5 pairs late
        cfg_write(2'd1, 16'd0);
        cfg_write(2'd2, 16'd500);
        wait_ph1(); a = p - 1; cfg_write(2'd0, 16'h2); q0 = a + 1 - DLY;
        repeat (20) step();
        wait_ph1(); t = p - 1; cfg_write(2'd0, 16'h1); p0 = t + 2;
        n = 0;
        while (!cap_done && n < 1000) begin step(); n++; end
        chk(cap_done == 1, "R7 done after full-depth capture", cap_done, 1);
        for (int q = t - 3; q < p; q++) begin
            if (q < p0) begin
                chk(bI[q] == 0 && bQ[q] == 0, "R2 zero before trigger", {bI[q], bQ[q]}, 0);
            end else begin
                chk(bI[q] == tone(q - p0, 0), "R3 tone I", bI[q], tone(q - p0, 0));
                chk(bQ[q] == tone(q - p0, 1), "R3 tone Q", bQ[q], tone(q - p0, 1));
            end
        end
        chk(echo_seen == 1 && echo_lat == 5, "R8 echo latency 5", {echo_seen, echo_lat}, {1'b1, 6'd5});
        for (int k = 0; k < DEPTH; k++) begin
            rd(k, v);
            old_cap[k] = v;
            qq = q0 + k;
            ex = {bI[qq], bQ[qq], rI[qq], rQ[qq]};
            chk(v == ex, "R6 entry alignment", v, ex);
        end
        v = old_cap[p0 - q0];
        chk(v[63:48] == 16'(AMP) && v[47:32] == 0, "R5 tx fields of first tone entry", v, {16'(AMP), 48'd0});
        v = old_cap[p0 + 5 - q0];
        chk(v[31:16] == 16'(AMP) && v[15:0] == 0, "R5 rx fields of first echo entry", v[31:0], {16'(AMP), 16'd0});
        rd(3, v);
        rd_addr = AW'(4);
        #1;
        chk(rd_data == old_cap[3], "R10 data held before edge", rd_data, old_cap[3]);
        step();
        chk(rd_data == old_cap[4], "R10 data after one clock", rd_data, old_cap[4]);
        repeat (10) step();
        chk(cap_done == 1, "R7 done stays high", cap_done, 1);

        // ---- run 2: trigger off, short capture, inverted echo 9 pairs late
        wait_ph1(); toff = p - 1; cfg_write(2'd0, 16'h0);
        repeat (24) step();
        for (int q = toff + 2; q < p; q++)
            chk(bI[q] == 0 && bQ[q] == 0, "R4 zero after trigger cleared", {bI[q], bQ[q]}, 0);
        chk(echo_seen == 1 && echo_lat == 5, "R8 result frozen", {echo_seen, echo_lat}, {1'b1, 6'd5});
        echo_d = 9; echo_s = -1;
        cfg_write(2'd1, 16'd8);
        wait_ph1(); a = p - 1; cfg_write(2'd0, 16'h2); q0 = a + 1 - DLY;
        step(); step();
        chk(cap_done == 0, "R7 arm clears done", cap_done, 0);
        repeat (6) step();
        wait_ph1(); t = p - 1; cfg_write(2'd0, 16'h1); p0 = t + 2;
        n = 0;
        while (!cap_done && n < 1000) begin step(); n++; end
        chk(cap_done == 1, "R7 done after short capture", cap_done, 1);
        repeat (40) step();
        chk(bI[p0] == 16'(AMP) && bQ[p0] == 0 && bI[p0-1] == 0, "R4 tone restarts at phase 0",
            {bI[p0-1], bI[p0], bQ[p0]}, {16'd0, 16'(AMP), 16'd0});
        chk(echo_seen == 1 && echo_lat == 9, "R12 negative echo counted", {echo_seen, echo_lat}, {1'b1, 6'd9});
        for (int k = 0; k < 8; k++) begin
            rd(k, v);
            qq = q0 + k;
            ex = {bI[qq], bQ[qq], rI[qq], rQ[qq]};
            chk(v == ex, "R6 short capture entry", v, ex);
        end
        rd(8, v);
        chk(v == old_cap[8], "R7 entry past length untouched", v, old_cap[8]);
        rd(63, v);
        chk(v == old_cap[63], "R7 last entry untouched", v, old_cap[63]);

        // ---- run 3: threshold equal to amplitude, no echo qualifies
        cfg_write(2'd2, 16'(AMP));
        cfg_write(2'd0, 16'h0);
        repeat (8) step();
        cfg_write(2'd0, 16'h1);
        repeat (200) step();
        chk(echo_seen == 0 && echo_lat == 6'd63, "R9 saturated without echo", {echo_seen, echo_lat}, {1'b0, 6'd63});

        chk(ph_err == 0, "R1 slot flag alternation", ph_err, 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule